// File: doc/BRIEF.md
# Pin Function Mux with Sleep Override

This block decides, for every pin of a 32-pin I/O bank, which source drives the pad: the GPIO core or one of three peripheral ports (A, B and C). Each pin's choice is coded by one bit in each of two select registers. A third register holds a per-pin sleep-keep bit. All three are written and read through a small register port.

A platform-level force signal marks low-power entry. It passes through a two-flop synchroniser. While it is active, every pin whose sleep-keep bit is clear is pulled back to GPIO control and has wake-up detection enabled. A pin whose bit is set keeps its normal selection and has wake-up detection disabled. When the force drops, every pin returns to the function in its select registers.

Pull controls come from the GPIO core on every pin, whatever function is selected.

Top module: `pin_func_mux`

## Requirements
- R1: After reset both select registers read 0, every pin is in GPIO mode, the sleep-keep register reads all ones, and `wake_en_o` is 0.
- R2: The register port uses these addresses: 0 is the select-low register, 1 is the select-high register, and 2 is the sleep-keep register. A write replaces the whole word from the next clock edge. A read returns the full word combinationally.
- R3: Without force, pin i takes the code {select-high[i], select-low[i]}. The codes are 00 for GPIO, 01 for port A, 10 for port B and 11 for port C. `pad_out_o[i]` and `pad_oe_o[i]` are that source's output and enable bits.
- R4: While the synchronised force is high, a pin whose sleep-keep bit is 0 is driven by the GPIO core, whatever its select bits hold.
- R5: While the synchronised force is high, a pin whose sleep-keep bit is 1 keeps the function given by its select bits.
- R6: `wake_en_o[i]` is 1 exactly when the synchronised force is high and sleep-keep bit i is 0.
- R7: Once the synchronised force is low again, every pin follows its select bits.
- R8: `sleep_force_i` affects the outputs only after two rising clock edges. Sampled after the first edge, the outputs still show the old force state.
- R9: `pad_pull_en_o` and `pad_pull_up_o` equal the GPIO core's pull inputs on every pin, in every function and force state.
- R10: Address 3 reads as 0. A write to it changes none of the three registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (read and write) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| sleep_force_i | input | 1 | Asynchronous low-power force request |
| gpio_out_i | input | 32 | GPIO core output values |
| gpio_oe_i | input | 32 | GPIO core output enables |
| gpio_pull_en_i | input | 32 | GPIO core pull enables |
| gpio_pull_up_i | input | 32 | GPIO core pull direction (1 = up) |
| fa_out_i | input | 32 | Port A output values |
| fa_oe_i | input | 32 | Port A output enables |
| fb_out_i | input | 32 | Port B output values |
| fb_oe_i | input | 32 | Port B output enables |
| fc_out_i | input | 32 | Port C output values |
| fc_oe_i | input | 32 | Port C output enables |
| pad_out_o | output | 32 | Effective pad output value |
| pad_oe_o | output | 32 | Effective pad output enable |
| pad_pull_en_o | output | 32 | Pad pull enable |
| pad_pull_up_o | output | 32 | Pad pull direction |
| wake_en_o | output | 32 | Per-pin wake-up detection enable |

## Verification
The assertions check several properties on every cycle:
- Wake enable never rises on a pin whose keep bit is set, and any wake enable implies the force input was high two edges earlier.
- Pins coded 00 always show the GPIO core.
- Pulls always pass through unchanged.
- The registers hold without a write and come out of reset at their defined values.

Some behaviour only the bench scenarios can show. These are:
- the exact latency of force entry and exit;
- the per-pin split between forced and kept pins under a mixed keep mask;
- restoration of peripheral functions after force drops;
- the inertness of address 3.

The reference model is compared against all outputs every cycle to cover these.

// File: rtl/pfm_pkg.sv
package pfm_pkg;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_A    = 2'b01,
        FN_B    = 2'b10,
        FN_C    = 2'b11
    } pin_fn_e;

    typedef enum logic [REG_AW-1:0] {
        RA_SEL_LO = 2'd0,
        RA_SEL_HI = 2'd1,
        RA_KEEP   = 2'd2,
        RA_VOID   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic val;
        logic en;
    } drive_t;

    typedef struct packed {
        logic en;
        logic up;
    } pull_t;

    // Effective function of one pin given its select bits and force state.
    function automatic pin_fn_e resolve_fn(logic lo, logic hi, logic forced, logic keep);
        if (forced && !keep) begin
            return FN_GPIO;
        end
        return pin_fn_e'({hi, lo});
    endfunction
endpackage

// File: rtl/pfm_regfile.sv
module pfm_regfile
    import pfm_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   addr,
    input  logic [NPINS-1:0]    wdata,
    output logic [NPINS-1:0]    rdata,
    output logic [NPINS-1:0]    sel_lo,
    output logic [NPINS-1:0]    sel_hi,
    output logic [NPINS-1:0]    keep
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_lo <= '0;
            sel_hi <= '0;
            keep   <= '1;
        end else if (wr_en) begin
            case (reg_addr_e'(addr))
                RA_SEL_LO: sel_lo <= wdata;
                RA_SEL_HI: sel_hi <= wdata;
                RA_KEEP:   keep   <= wdata;
                default:   ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_SEL_LO: rdata = sel_lo;
            RA_SEL_HI: rdata = sel_hi;
            RA_KEEP:   rdata = keep;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/pfm_sync2.sv
module pfm_sync2 #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else begin
            stg <= {stg[STAGES-2:0], d};
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pfm_lane.sv
module pfm_lane
    import pfm_pkg::*;
(
    input  logic   sel_lo,
    input  logic   sel_hi,
    input  logic   keep,
    input  logic   forced,
    input  drive_t gpio_drv,
    input  pull_t  gpio_pull,
    input  drive_t fa_drv,
    input  drive_t fb_drv,
    input  drive_t fc_drv,
    output drive_t pad_drv,
    output pull_t  pad_pull,
    output logic   wake
);
    pin_fn_e fn;

    always_comb begin
        fn = resolve_fn(sel_lo, sel_hi, forced, keep);
        unique case (fn)
            FN_A:    pad_drv = fa_drv;
            FN_B:    pad_drv = fb_drv;
            FN_C:    pad_drv = fc_drv;
            default: pad_drv = gpio_drv;
        endcase
    end

    assign pad_pull = gpio_pull;
    assign wake     = forced & ~keep;
endmodule

// File: rtl/pin_func_mux.sv
module pin_func_mux
    import pfm_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    input  logic              sleep_force_i,
    input  logic [NPINS-1:0]  gpio_out_i,
    input  logic [NPINS-1:0]  gpio_oe_i,
    input  logic [NPINS-1:0]  gpio_pull_en_i,
    input  logic [NPINS-1:0]  gpio_pull_up_i,
    input  logic [NPINS-1:0]  fa_out_i,
    input  logic [NPINS-1:0]  fa_oe_i,
    input  logic [NPINS-1:0]  fb_out_i,
    input  logic [NPINS-1:0]  fb_oe_i,
    input  logic [NPINS-1:0]  fc_out_i,
    input  logic [NPINS-1:0]  fc_oe_i,
    output logic [NPINS-1:0]  pad_out_o,
    output logic [NPINS-1:0]  pad_oe_o,
    output logic [NPINS-1:0]  pad_pull_en_o,
    output logic [NPINS-1:0]  pad_pull_up_o,
    output logic [NPINS-1:0]  wake_en_o
);
    logic [NPINS-1:0] sel_lo;
    logic [NPINS-1:0] sel_hi;
    logic [NPINS-1:0] sleep_keep;
    logic             force_s;

    pfm_regfile #(.NPINS(NPINS)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .sel_lo (sel_lo),
        .sel_hi (sel_hi),
        .keep   (sleep_keep)
    );

    pfm_sync2 #(.STAGES(2)) u_force_sync (
        .clk (clk),
        .rst (rst),
        .d   (sleep_force_i),
        .q   (force_s)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_lane
        drive_t drv_o;
        pull_t  pull_o;

        pfm_lane u_lane (
            .sel_lo    (sel_lo[i]),
            .sel_hi    (sel_hi[i]),
            .keep      (sleep_keep[i]),
            .forced    (force_s),
            .gpio_drv  ('{val: gpio_out_i[i], en: gpio_oe_i[i]}),
            .gpio_pull ('{en: gpio_pull_en_i[i], up: gpio_pull_up_i[i]}),
            .fa_drv    ('{val: fa_out_i[i], en: fa_oe_i[i]}),
            .fb_drv    ('{val: fb_out_i[i], en: fb_oe_i[i]}),
            .fc_drv    ('{val: fc_out_i[i], en: fc_oe_i[i]}),
            .pad_drv   (drv_o),
            .pad_pull  (pull_o),
            .wake      (wake_en_o[i])
        );

        assign pad_out_o[i]     = drv_o.val;
        assign pad_oe_o[i]      = drv_o.en;
        assign pad_pull_en_o[i] = pull_o.en;
        assign pad_pull_up_o[i] = pull_o.up;
    end
endmodule

// File: rtl/pfm_checker.sv
module pfm_checker #(
    parameter int unsigned NPINS = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             reg_wr,
    input logic             force_i,
    input logic [NPINS-1:0] sel_lo,
    input logic [NPINS-1:0] sel_hi,
    input logic [NPINS-1:0] keep,
    input logic [NPINS-1:0] gpio_out,
    input logic [NPINS-1:0] gpio_oe,
    input logic [NPINS-1:0] gpio_pull_en,
    input logic [NPINS-1:0] gpio_pull_up,
    input logic [NPINS-1:0] pad_out,
    input logic [NPINS-1:0] pad_oe,
    input logic [NPINS-1:0] pad_pull_en,
    input logic [NPINS-1:0] pad_pull_up,
    input logic [NPINS-1:0] wake_en
);
    logic [NPINS-1:0] gpio_coded;
    assign gpio_coded = ~sel_lo & ~sel_hi;

    p_reset_vals_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (sel_lo == '0 && sel_hi == '0 && keep == '1));

    p_hold_regs_r2: assert property (@(posedge clk) disable iff (rst)
        !reg_wr |=> ($stable(sel_lo) && $stable(sel_hi) && $stable(keep)));

    p_gpio_code_r3: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & gpio_coded) == (gpio_out & gpio_coded)) &&
        ((pad_oe & gpio_coded) == (gpio_oe & gpio_coded)));

    p_no_wake_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (wake_en & keep) == '0);

    p_wake_latency_r8: assert property (@(posedge clk) disable iff (rst)
        (|wake_en) |-> $past(force_i, 2));

    p_pull_pass_r9: assert property (@(posedge clk) disable iff (rst)
        pad_pull_en == gpio_pull_en && pad_pull_up == gpio_pull_up);
endmodule

bind pin_func_mux pfm_checker #(.NPINS(NPINS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .reg_wr       (reg_wr),
    .force_i      (sleep_force_i),
    .sel_lo       (sel_lo),
    .sel_hi       (sel_hi),
    .keep         (sleep_keep),
    .gpio_out     (gpio_out_i),
    .gpio_oe      (gpio_oe_i),
    .gpio_pull_en (gpio_pull_en_i),
    .gpio_pull_up (gpio_pull_up_i),
    .pad_out      (pad_out_o),
    .pad_oe       (pad_oe_o),
    .pad_pull_en  (pad_pull_en_o),
    .pad_pull_up  (pad_pull_up_o),
    .wake_en      (wake_en_o)
);

// File: tb/pin_func_mux_tb.sv
module pin_func_mux_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sleep_force = 1'b0;
    logic [31:0] g_out = '0, g_oe = '0, g_pe = '0, g_pu = '0;
    logic [31:0] a_out = '0, a_oe = '0, b_out = '0, b_oe = '0, c_out = '0, c_oe = '0;
    logic [31:0] p_out, p_oe, p_pe, p_pu, wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_func_mux u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sleep_force_i(sleep_force),
        .gpio_out_i(g_out), .gpio_oe_i(g_oe), .gpio_pull_en_i(g_pe), .gpio_pull_up_i(g_pu),
        .fa_out_i(a_out), .fa_oe_i(a_oe), .fb_out_i(b_out), .fb_oe_i(b_oe),
        .fc_out_i(c_out), .fc_oe_i(c_oe),
        .pad_out_o(p_out), .pad_oe_o(p_oe), .pad_pull_en_o(p_pe), .pad_pull_up_o(p_pu),
        .wake_en_o(wake)
    );

    // Behavioural reference state
    logic [31:0] m_lo, m_hi, m_keep;
    logic [1:0]  fpipe;

    always @(posedge clk) begin
        if (rst) begin
            m_lo = '0; m_hi = '0; m_keep = '1; fpipe = 2'b00;
        end else begin
            if (reg_wr) begin
                if (reg_addr == 2'd0) m_lo = reg_wdata;
                else if (reg_addr == 2'd1) m_hi = reg_wdata;
                else if (reg_addr == 2'd2) m_keep = reg_wdata;
            end
            fpipe = {fpipe[0], sleep_force};
        end
    end

    function automatic logic [63:0] model_drive(logic forced);
        logic [31:0] o, e;
        for (int i = 0; i < 32; i++) begin
            int code;
            code = (forced && !m_keep[i]) ? 0 : (m_hi[i] * 2 + m_lo[i]);
            case (code)
                1: begin o[i] = a_out[i]; e[i] = a_oe[i]; end
                2: begin o[i] = b_out[i]; e[i] = b_oe[i]; end
                3: begin o[i] = c_out[i]; e[i] = c_oe[i]; end
                default: begin o[i] = g_out[i]; e[i] = g_oe[i]; end
            endcase
        end
        return {o, e};
    endfunction

    function automatic logic [31:0] model_rd();
        case (reg_addr)
            2'd0: return m_lo;
            2'd1: return m_hi;
            2'd2: return m_keep;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            logic [63:0] d;
            d = model_drive(fpipe[1]);
            chk(fpipe[1] ? "R4/R5 pad_out" : "R3 pad_out", p_out, d[63:32]);
            chk(fpipe[1] ? "R4/R5 pad_oe" : "R3 pad_oe", p_oe, d[31:0]);
            chk("R6 wake", wake, fpipe[1] ? ~m_keep : 32'h0);
            chk("R9 pull_en", p_pe, g_pe);
            chk("R9 pull_up", p_pu, g_pu);
            chk("R2 rdata", reg_rdata, model_rd());
        end
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic shuffle_src();
        g_out = $urandom; g_oe = $urandom; g_pe = $urandom; g_pu = $urandom;
        a_out = $urandom; a_oe = $urandom; b_out = $urandom; b_oe = $urandom;
        c_out = $urandom; c_oe = $urandom;
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(string tag, logic [1:0] a, logic [31:0] exp);
        reg_addr = a;
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        step();
    endtask

    initial begin
        shuffle_src();
        repeat (4) step();
        rst = 1'b0;
        @(negedge clk);
        chk("R1 pad_out gpio", p_out, g_out);
        chk("R1 wake", wake, 32'h0);
        step();
        rd_chk("R1 sel_lo", 2'd0, 32'h0);
        rd_chk("R1 sel_hi", 2'd1, 32'h0);
        rd_chk("R1 keep", 2'd2, 32'hFFFF_FFFF);

        // Register writes and normal selection
        wr(2'd0, 32'hFFFF_0000);
        wr(2'd1, 32'hFF00_FF00);
        rd_chk("R2 sel_lo", 2'd0, 32'hFFFF_0000);
        rd_chk("R2 sel_hi", 2'd1, 32'hFF00_FF00);
        for (int k = 0; k < 40; k++) begin
            shuffle_src();
            if (k % 7 == 3) wr(2'(k % 2), $urandom); else step();
        end

        // Force entry with a mixed keep mask
        wr(2'd0, 32'hFFFF_0000);
        wr(2'd1, 32'hFF00_FF00);
        wr(2'd2, 32'h0F0F_33CC);
        sleep_force = 1'b1;
        step();
        @(negedge clk);
        chk("R8 wake after one edge", wake, 32'h0);
        step();
        @(negedge clk);
        chk("R8 wake after two edges", wake, ~32'h0F0F_33CC);
        chk("R4 forced pins follow gpio", p_out & ~32'h0F0F_33CC, g_out & ~32'h0F0F_33CC);
        chk("R5 kept port C pins", p_out & 32'h0F00_0000, c_out & 32'h0F00_0000);
        step();

        // Address 3 inert
        wr(2'd3, 32'hDEAD_BEEF);
        rd_chk("R10 void reads 0", 2'd3, 32'h0);
        rd_chk("R10 sel_lo unchanged", 2'd0, 32'hFFFF_0000);
        rd_chk("R10 sel_hi unchanged", 2'd1, 32'hFF00_FF00);
        rd_chk("R10 keep unchanged", 2'd2, 32'h0F0F_33CC);

        // Force exit
        sleep_force = 1'b0;
        step();
        @(negedge clk);
        chk("R8 still forced after one edge", wake, ~32'h0F0F_33CC);
        step();
        @(negedge clk);
        chk("R7 port C restored", p_out & 32'hFF00_0000, c_out & 32'hFF00_0000);
        chk("R7 port A restored", p_out & 32'h00FF_0000, a_out & 32'h00FF_0000);
        chk("R7 wake cleared", wake, 32'h0);
        step();

        // All pins on port C, no keep, forced: everything back to gpio
        wr(2'd0, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0);
        sleep_force = 1'b1;
        step(); step();
        @(negedge clk);
        chk("R4 all forced out", p_out, g_out);
        chk("R4 all forced oe", p_oe, g_oe);
        chk("R9 pull under force", p_pe, g_pe);
        step();

        // Random mixed traffic with force toggling
        for (int k = 0; k < 120; k++) begin
            shuffle_src();
            if (k % 9 == 0) sleep_force = ~sleep_force;
            if (k % 5 == 2) wr(2'($urandom_range(0, 3)), $urandom); else step();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL R1 watchdog: actual=hung expected=complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule